// File: doc/BRIEF.md
# Power Management Event Aggregator

This block gathers wake events from a set of sources and turns them into a single power-management request pin. The sources are two ring indicator lines, keyboard data, mouse data, a fan tachometer event, a parameterised group of general-purpose pins and a group interrupt level. Each asynchronous input is synchronised and edge-detected. A qualifying edge sets a sticky status bit. An enable bit per source decides whether that status counts as pending.

A sticky global status flag records that some enabled source is pending. A global enable gates the request pin. The pin's active level and its drive type are programmable, and the drive type is modelled as a data value plus a pad output-enable. Software reaches the control word, three status/enable pairs and the pin edge configuration through a byte-wide register port with separate read and write addresses. Reads are combinational. Writes take effect at the clock edge.

Register offsets (hex): 0 control, 1 status A, 2 enable A, 3 GPIO status, 4 GPIO enable, 5 status C, 6 enable C, 7 GPIO invert mask, 8 GPIO both-edge mask, 9 routing.

Top module: `pme_aggregator`

## Requirements
- R1: While the global enable (control bit 0) is 0, the request pin stays at its inactive level, whatever the status bits are.
- R2: With the global enable at 1, the pin is at its active level whenever any source has both its status bit and its enable bit at 1.
- R3: The global status flag (control bit 1) is set one clock after any enabled source is pending, whatever the global enable is.
- R4: Writing 1 to control bit 1 clears the global status flag only while no enabled source is pending. Otherwise the flag stays set.
- R5: Status bits clear when 1 is written to them, and writing 0 leaves them unchanged. If a set condition and a clear fall in the same cycle, the set wins.
- R6: GPIO pin k sets bit k of the GPIO status register on a rising edge by default. With bit k of the invert mask at 1, it sets on a falling edge instead. With bit k of the both-edge mask at 1, either edge sets it.
- R7: Control bit 6 selects active-high (1) or active-low (0). Control bit 7 selects push-pull (1) or open-drain (0). In open-drain mode the output-enable is high only while the pin drives 0. In push-pull mode the output-enable is always high. After reset the pin is active-low and open-drain, so it reads pin=1 and oe=0.
- R8: Bit 3 of status C mirrors the synchronised group interrupt level only while bit 5 of the routing register is 1. Otherwise the bit reads 0.
- R9: In status A, bit 0 and bit 1 are the ring indicators and are set by either edge. Bit 2 is keyboard data and bit 3 is mouse data, both set by a falling edge. Bit 4 is the tachometer event, set by a rising edge. A status bit can be read 3 clocks after its input changes, and one transition sets it only once.
- R10: Status bits set on qualifying edges even when their enable bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ring_a | input | 1 | First ring indicator |
| ring_b | input | 1 | Second ring indicator |
| kbd_dat | input | 1 | Keyboard data line |
| ms_dat | input | 1 | Mouse data line |
| tach_evt | input | 1 | Fan tachometer event |
| gpio_in | input | N_GPIO | General-purpose wake pins |
| grp_irq | input | 1 | Group interrupt level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read offset |
| rd_data | output | 8 | Read data (combinational) |
| pme_pin | output | 1 | Request pin value |
| pme_oe | output | 1 | Pad output-enable |

## Verification
An input change becomes visible in the status registers after three rising edges: two synchroniser stages and one edge register. The global status flag follows one edge after that. The pin and read data follow the registers combinationally, and a write lands at the next edge. The bench therefore waits at least four edges after each stimulus or write before it queues any expected values. The monitor compares them at a falling edge, after setting the read address and allowing a short settle.

// File: rtl/pme_aggregator.sv
module pme_aggregator #(
  parameter int N_GPIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_a,
  input  logic              ring_b,
  input  logic              kbd_dat,
  input  logic              ms_dat,
  input  logic              tach_evt,
  input  logic [N_GPIO-1:0] gpio_in,
  input  logic              grp_irq,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [3:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic              pme_pin,
  output logic              pme_oe
);
  localparam int NSRC = 5;
  localparam int NIN  = NSRC + N_GPIO + 1;

  logic [NIN-1:0] raw, s1, s2, s3;
  assign raw = {grp_irq, gpio_in, tach_evt, ms_dat, kbd_dat, ring_b, ring_a};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= raw; s2 <= s1; s3 <= s2;
    end

  wire [NIN-1:0] rise = s2 & ~s3;
  wire [NIN-1:0] fall = ~s2 & s3;

  logic [NSRC-1:0]   sts_a, en_a;
  logic [N_GPIO-1:0] sts_g, en_g, inv_g, both_g;
  logic              en_c, gen, act_hi, push_pull, gsts;
  logic [7:0]        route;

  wire [NSRC-1:0] set_a = {rise[4], fall[3], fall[2], rise[1] | fall[1], rise[0] | fall[0]};

  logic [N_GPIO-1:0] set_g;
  for (genvar k = 0; k < N_GPIO; k++) begin : g_edge
    assign set_g[k] = both_g[k] ? (rise[NSRC+k] | fall[NSRC+k])
                                : (inv_g[k] ? fall[NSRC+k] : rise[NSRC+k]);
  end

  wire mirror  = route[5] & s2[NIN-1];
  wire pending = |(sts_a & en_a) | |(sts_g & en_g) | (mirror & en_c);
  wire wr_ctl  = wr_en && wr_addr == 4'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sts_a <= '0; en_a <= '0; sts_g <= '0; en_g <= '0;
      inv_g <= '0; both_g <= '0; en_c <= 1'b0; route <= '0;
      gen <= 1'b0; act_hi <= 1'b0; push_pull <= 1'b0; gsts <= 1'b0;
    end else begin
      sts_a <= (sts_a & ~((wr_en && wr_addr == 4'd1) ? wr_data[NSRC-1:0] : '0)) | set_a;
      sts_g <= (sts_g & ~((wr_en && wr_addr == 4'd3) ? wr_data[N_GPIO-1:0] : '0)) | set_g;
      if (pending)                gsts <= 1'b1;
      else if (wr_ctl && wr_data[1]) gsts <= 1'b0;
      if (wr_ctl) begin
        gen <= wr_data[0]; act_hi <= wr_data[6]; push_pull <= wr_data[7];
      end
      if (wr_en) begin
        case (wr_addr)
          4'd2: en_a   <= wr_data[NSRC-1:0];
          4'd4: en_g   <= wr_data[N_GPIO-1:0];
          4'd6: en_c   <= wr_data[3];
          4'd7: inv_g  <= wr_data[N_GPIO-1:0];
          4'd8: both_g <= wr_data[N_GPIO-1:0];
          4'd9: route  <= wr_data;
          default: ;
        endcase
      end
    end

  always_comb
    case (rd_addr)
      4'd0:    rd_data = {push_pull, act_hi, 4'b0, gsts, gen};
      4'd1:    rd_data = 8'(sts_a);
      4'd2:    rd_data = 8'(en_a);
      4'd3:    rd_data = 8'(sts_g);
      4'd4:    rd_data = 8'(en_g);
      4'd5:    rd_data = {4'b0, mirror, 3'b0};
      4'd6:    rd_data = {4'b0, en_c, 3'b0};
      4'd7:    rd_data = 8'(inv_g);
      4'd8:    rd_data = 8'(both_g);
      4'd9:    rd_data = route;
      default: rd_data = 8'h00;
    endcase

  wire req = gen & pending;
  assign pme_pin = act_hi ? req : ~req;
  assign pme_oe  = push_pull | ~pme_pin;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |-> pme_pin == ~act_hi); // R1
  AST_GSTS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> gsts); // R3
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd1 && wr_data == 8'h00) |=> ((sts_a & $past(sts_a)) == $past(sts_a))); // R5
  AST_OD_SINKS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_pull && pme_oe) |-> !pme_pin); // R7
  AST_MIRROR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !route[5] |-> rd_addr != 4'd5 || rd_data == 8'h00); // R8
endmodule

// File: tb/pme_aggregator_test.sv
`timescale 1ns/1ps
module pme_aggregator_test;
  logic clk = 0, rst_n = 0;
  logic ring_a = 0, ring_b = 0, kbd_dat = 1, ms_dat = 1, tach_evt = 0, grp_irq = 0;
  logic [3:0] gpio_in = '0;
  logic wr_en = 0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic pme_pin, pme_oe;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pme_aggregator #(.N_GPIO(4)) uut (.*);

  typedef struct { bit pin; logic [3:0] a; logic [7:0] e; string r; } item_t;
  item_t q[$];

  task automatic exp_reg(input logic [3:0] a, input logic [7:0] e, input string r);
    q.push_back('{1'b0, a, e, r});
  endtask
  task automatic exp_pin(input logic oe, input logic pin, input string r);
    q.push_back('{1'b1, 4'd0, {6'b0, oe, pin}, r});
  endtask
  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask
  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial forever begin
    @(negedge clk);
    if (q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = q.pop_front();
      rd_addr = it.a;
      #1;
      got = it.pin ? {6'b0, pme_oe, pme_pin} : rd_data;
      vectors++;
      if (got !== it.e) begin
        miscompares++;
        $display("FAIL %s: addr %0h got %02h expected %02h", it.r, it.a, got, it.e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    exp_reg(0, 8'h00, "R7 reset ctrl"); exp_pin(0, 1, "R7 reset pin"); exp_reg(1, 8'h00, "R9 reset sts");
    drain();
    // R10: status latches with enable off
    tach_evt = 1; settle();
    exp_reg(1, 8'h10, "R10 tach latched"); exp_reg(0, 8'h00, "R3 gsts idle"); exp_pin(0, 1, "R1 idle");
    drain();
    wr(2, 8'h10); settle();
    exp_reg(0, 8'h02, "R3 gsts set with gen off"); exp_pin(0, 1, "R1 gated");
    drain();
    wr(0, 8'h03); settle();
    exp_reg(0, 8'h03, "R4 gsts held"); exp_pin(1, 0, "R2 active low");
    drain();
    wr(1, 8'h00); settle();
    exp_reg(1, 8'h10, "R5 zero write");
    drain();
    wr(1, 8'h10); settle();
    exp_reg(1, 8'h00, "R5 w1c"); exp_reg(0, 8'h03, "R4 gsts sticky"); exp_pin(0, 1, "R2 released");
    drain();
    wr(0, 8'h03); settle();
    exp_reg(0, 8'h01, "R4 gsts cleared");
    drain();
    wr(0, 8'hC1); settle();
    exp_pin(1, 0, "R7 push-pull active high idle");
    drain();
    wr(0, 8'h41); settle();
    exp_pin(1, 0, "R7 open-drain active high idle");
    drain();
    wr(0, 8'h01);
    // R6 gpio edges
    gpio_in[0] = 1; settle(); exp_reg(3, 8'h01, "R6 rise"); drain();
    gpio_in[0] = 0; wr(3, 8'h01); settle(); exp_reg(3, 8'h00, "R6 fall ignored"); drain();
    wr(7, 8'h02);
    gpio_in[1] = 1; settle(); exp_reg(3, 8'h00, "R6 inverted rise ignored"); drain();
    gpio_in[1] = 0; settle(); exp_reg(3, 8'h02, "R6 inverted fall"); drain();
    wr(3, 8'hFF); wr(8, 8'h04);
    gpio_in[2] = 1; settle(); exp_reg(3, 8'h04, "R6 both rise"); drain();
    wr(3, 8'h04); gpio_in[2] = 0; settle(); exp_reg(3, 8'h04, "R6 both fall"); drain();
    wr(3, 8'hFF);
    // R9 per-source edges
    kbd_dat = 0; settle(); exp_reg(1, 8'h04, "R9 kbd fall"); drain();
    wr(1, 8'hFF); kbd_dat = 1; settle(); exp_reg(1, 8'h00, "R9 kbd rise ignored"); drain();
    ms_dat = 0; settle(); exp_reg(1, 8'h08, "R9 mouse fall"); drain();
    wr(1, 8'hFF); settle(); exp_reg(1, 8'h00, "R9 set once"); drain();
    ring_a = 1; settle(); exp_reg(1, 8'h01, "R9 ring a rise"); drain();
    wr(1, 8'hFF); ring_a = 0; settle(); exp_reg(1, 8'h01, "R9 ring a fall"); drain();
    wr(1, 8'hFF); ring_b = 1; settle(); exp_reg(1, 8'h02, "R9 ring b"); drain();
    wr(1, 8'hFF);
    // R8 group mirror
    grp_irq = 1; settle(); exp_reg(5, 8'h00, "R8 unrouted"); drain();
    wr(9, 8'h20); wr(6, 8'h08); settle();
    exp_reg(5, 8'h08, "R8 routed"); exp_pin(1, 0, "R2 mirror drives pin");
    drain();
    grp_irq = 0; settle(); exp_reg(5, 8'h00, "R8 follows level"); drain();
    // R5 set wins over same-cycle clear
    @(negedge clk); tach_evt = 0;
    @(negedge clk); @(negedge clk);
    tach_evt = 1;
    @(negedge clk); @(negedge clk);
    wr_en = 1; wr_addr = 4'd1; wr_data = 8'h10;
    @(negedge clk); wr_en = 0;
    settle(); exp_reg(1, 8'h10, "R5 set wins"); drain();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule